// File: doc/BRIEF.md
# Two-Wire Register Slave with Write-Cycle Busy Polling

This block is a slave on a two-wire serial bus in front of a small byte register array. It takes oversampled clock and data lines, brings them into the system clock domain, detects START and STOP, and recognises a fixed 7-bit device address. A write transaction first loads an internal word pointer and then stores data bytes at that pointer. A read transaction streams bytes out from the pointer for as long as the master keeps acknowledging. The data line is driven only as an active-low pull enable.

Written bytes are not placed in the array at once. They are held as pending until the write transaction ends with STOP. The STOP then starts an internal write cycle of a programmable number of system clocks. While that cycle runs the slave refuses its own address. A master therefore learns that the write has finished by sending the address over and over until it is acknowledged. When the cycle ends, the pending bytes are committed to the array.

Top module: `i2c_poll_slave`

## Requirements
- R1: Before the first START after reset, clocked bus traffic gets no response: a full address byte that matches is not acknowledged.
- R2: A STOP (data rising while the clock is high) returns the slave to idle, with the data line released on the following clock.
- R3: Apart from the release on START or STOP, the data-line enable changes only while the synchronised clock is low.
- R4: The byte after a START is the address byte, with the device address in bits 7..1 and read/write in bit 0 (1 = read). On a match the slave pulls data low for the whole ninth clock. On a mismatch it leaves the line released and ignores the bus until the next START or STOP.
- R5: In a write, every byte after the address byte is acknowledged. The first of these bytes sets the word pointer, reduced modulo the array depth.
- R6: Each later write byte is stored at the pointer, and the pointer then advances by one, wrapping from depth-1 to 0.
- R7: A read sends the byte at the pointer, most significant bit first, and then advances the pointer. While the master acknowledges (data low on the ninth clock), the next byte follows.
- R8: When the master does not acknowledge a read byte, the slave releases the line and drives nothing more until START or STOP.
- R9: A STOP that ends a transaction holding pending write bytes raises busy three system clocks after the STOP reaches the pins, and busy then stays high for exactly WCYC_CLKS clocks. A STOP with no pending bytes leaves busy low.
- R10: While busy is high, an address byte that matches is not acknowledged. After busy falls it is acknowledged again.
- R11: Pending bytes reach the array when busy falls. After reset the array reads as zero, busy is low and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High to pull the data line low (open drain) |
| busy | output | 1 | High while the internal write cycle runs |

## Verification
The assertions assume a well-behaved master. Outside START and STOP, the data line changes only while the clock is low. Each clock phase lasts longer than the synchroniser delay, so the slave's changes on the falling edge settle before the next rising edge. The bench drives its lines on falling system-clock edges, holds every bus half-period for eight system clocks, and moves its own data value only during the low phase. The bus line the slave sees is the AND of the master's value and the slave's release. In the bench, the time base for busy is taken from the STOP the bench itself issues.

// File: rtl/i2c_poll_pkg.sv
package i2c_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } link_st_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_PTR,
    PH_DATA
  } rx_phase_e;

  // Address byte carries the device address in its upper seven bits.
  function automatic logic dev_match(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // Pointer advance with wrap at the array depth.
  function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  // Word address byte reduced into the array.
  function automatic int unsigned idx_of(input logic [7:0] b, input int unsigned depth);
    return 32'(b) % depth;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] held;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    logic              last;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe <= '1;
        last <= 1'b1;
      end else begin
        pipe <= {pipe[STAGES-2:0], raw[g]};
        last <= pipe[STAGES-1];
      end
    end
    assign synced[g] = pipe[STAGES-1];
    assign held[g]   = last;
  end

  assign scl_s     = synced[0];
  assign sda_s     = synced[1];
  assign scl_rise  = synced[0] & ~held[0];
  assign scl_fall  = ~synced[0] & held[0];
  assign start_evt = synced[0] & held[0] & held[1] & ~synced[1];
  assign stop_evt  = synced[0] & held[0] & ~held[1] & synced[1];

endmodule

// File: rtl/i2c_wcycle_store.sv
module i2c_wcycle_store #(
  parameter int DEPTH     = 16,
  parameter int AW        = 4,
  parameter int WCYC_CLKS = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop_evt,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic          busy
);
  localparam int CW = $clog2(WCYC_CLKS + 1);

  logic [7:0]       mem    [DEPTH];
  logic [7:0]       pend_d [DEPTH];
  logic [DEPTH-1:0] pend_v;
  logic             pend_new;
  logic [CW-1:0]    left;
  logic             cyc_start;
  logic             commit;

  assign busy      = (left != '0);
  assign cyc_start = stop_evt && pend_new && !busy;
  assign commit    = (left == CW'(1));
  assign rd_data   = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left     <= '0;
      pend_new <= 1'b0;
    end else begin
      if (cyc_start)   left <= CW'(WCYC_CLKS);
      else if (busy)   left <= left - CW'(1);
      if (wr_en)          pend_new <= 1'b1;
      else if (cyc_start) pend_new <= 1'b0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g]    <= '0;
        pend_d[g] <= '0;
        pend_v[g] <= 1'b0;
      end else if (wr_en && wr_idx == AW'(g)) begin
        pend_d[g] <= wr_data;
        pend_v[g] <= 1'b1;
      end else if (commit) begin
        if (pend_v[g]) mem[g] <= pend_d[g];
        pend_v[g] <= 1'b0;
      end
    end
  end

  // Bytes are accepted only while no write cycle is counting.
  assert_wr_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !busy);

  // A cycle never starts on top of a running one.
  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> !busy);

  // Once started, a cycle leaves nothing new behind when it ends.
  assert_commit_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!pend_new && pend_v == '0));

endmodule

// File: rtl/i2c_poll_ctrl.sv
module i2c_poll_ctrl
  import i2c_poll_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         DEPTH    = 16,
  parameter int         AW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          busy,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic [AW-1:0] rd_idx
);
  link_st_e      state;
  rx_phase_e     phase;
  logic [3:0]    bitcnt;
  logic [7:0]    rx_sh;
  logic [7:0]    tx_sh;
  logic [AW-1:0] ptr;
  logic [AW-1:0] ptr_next;
  logic          rnw;
  logic          mack;

  logic byte_done;
  logic addr_done;
  logic addr_match;
  logic addr_take;

  assign byte_done  = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
  assign addr_done  = byte_done && (phase == PH_DEV);
  assign addr_match = dev_match(rx_sh, DEV_ADDR);
  assign addr_take  = addr_match && !busy;
  assign ptr_next   = AW'(wrap_inc(32'(ptr), DEPTH));

  assign wr_en   = byte_done && (phase == PH_DATA);
  assign wr_idx  = ptr;
  assign wr_data = rx_sh;
  assign rd_idx  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      phase  <= PH_DEV;
      bitcnt <= '0;
      rx_sh  <= '0;
      tx_sh  <= '0;
      ptr    <= '0;
      rnw    <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      state  <= ST_RX;
      phase  <= PH_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            rx_sh  <= {rx_sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            unique case (phase)
              PH_DEV: begin
                if (addr_take) begin
                  rnw    <= rx_sh[0];
                  state  <= ST_ACK;
                  sda_oe <= 1'b1;
                end else begin
                  state <= ST_WAIT;
                end
              end
              PH_PTR: begin
                ptr    <= AW'(idx_of(rx_sh, DEPTH));
                state  <= ST_ACK;
                sda_oe <= 1'b1;
              end
              default: begin
                ptr    <= ptr_next;
                state  <= ST_ACK;
                sda_oe <= 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (phase == PH_DEV && rnw) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[7];
              ptr    <= ptr_next;
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
              phase  <= (phase == PH_DEV) ? PH_PTR : PH_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              bitcnt <= bitcnt + 4'd1;
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            bitcnt <= '0;
            if (mack) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[7];
              ptr    <= ptr_next;
              state  <= ST_TX;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // The drive may move only in the low clock phase.
  assert_sda_quiet_scl_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && !start_evt && !stop_evt) |=> $stable(sda_oe));

  // STOP always leaves the line released.
  assert_release_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // A foreign address is never acknowledged.
  assert_mismatch_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !addr_match) |=> !sda_oe);

  // Own address is refused while the write cycle runs.
  assert_nack_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && busy) |=> !sda_oe);

  // A missing master acknowledge ends driving.
  assert_read_nack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MACK && scl_fall && !mack && !start_evt && !stop_evt) |=> (!sda_oe && state == ST_WAIT));

endmodule

// File: rtl/i2c_poll_slave.sv
module i2c_poll_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         MEM_DEPTH   = 16,
  parameter int         WCYC_CLKS   = 500,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic busy
);
  localparam int AW = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;

  logic          scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic          wr_en;
  logic [AW-1:0] wr_idx, rd_idx;
  logic [7:0]    wr_data, rd_data;

  i2c_line_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  i2c_poll_ctrl #(
    .DEV_ADDR(DEV_ADDR),
    .DEPTH   (MEM_DEPTH),
    .AW      (AW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .busy     (busy),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx)
  );

  i2c_wcycle_store #(
    .DEPTH    (MEM_DEPTH),
    .AW       (AW),
    .WCYC_CLKS(WCYC_CLKS)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .stop_evt(stop_evt),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .busy    (busy)
  );

endmodule

// File: tb/i2c_poll_slave_bench.sv
`timescale 1ns/1ps
module i2c_poll_slave_bench;
  localparam int        DEPTH = 16;
  localparam int        WCYC  = 500;
  localparam int        HP    = 8;
  localparam logic [6:0] DEV  = 7'h50;
  localparam logic [7:0] AWR  = {DEV, 1'b0};
  localparam logic [7:0] ARD  = {DEV, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, busy;
  wire  sda_line = sda_m & ~sda_oe;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_poll_slave #(
    .DEV_ADDR (DEV),
    .MEM_DEPTH(DEPTH),
    .WCYC_CLKS(WCYC)
  ) u_i2c_poll_slave (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl),
    .sda_i (sda_line),
    .sda_oe(sda_oe),
    .busy  (busy)
  );

  // Behavioural reference: committed array, pending queue, busy timing.
  int m_mem [DEPTH];
  int m_q_idx[$];
  int m_q_val[$];
  bit m_new = 1'b0;
  int m_lat = 0;
  int m_left = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (m_lat > 0) begin
      m_lat--;
      if (m_lat == 0) m_left = WCYC;
    end else if (m_left > 0) begin
      m_left--;
      if (m_left == 0) begin
        foreach (m_q_idx[k]) m_mem[m_q_idx[k]] = m_q_val[k];
        m_q_idx.delete();
        m_q_val.delete();
      end
    end
  end

  // R9: busy compared with the reference on every clock.
  always @(negedge clk) begin
    if (rst_n && !done)
      chk(busy === (m_left > 0), "R9", "busy trace", int'(busy), int'(m_left > 0));
  end

  task automatic hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp();
    scl = 1'b1; hp();
    sda_m = 1'b0; hp();
    scl = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp();
    scl = 1'b1; hp();
    sda_m = 1'b1;
    if (m_new) begin
      m_lat = 3;
      m_new = 1'b0;
    end
    hp();
  endtask

  task automatic clk_bit(input bit b, output bit r);
    sda_m = b; hp();
    scl = 1'b1;
    repeat (HP/2) @(negedge clk);
    r = sda_line;
    repeat (HP - HP/2) @(negedge clk);
    scl = 1'b0; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      b[i] = r;
    end
    clk_bit(~give_ack, r);
  endtask

  task automatic write_data(input logic [7:0] v, input int idx);
    bit ack;
    send_byte(v, ack);
    chk(ack, "R5", "data byte ack", int'(ack), 1);
    m_q_idx.push_back(idx);
    m_q_val.push_back(int'(v));
    m_new = 1'b1;
  endtask

  task automatic poll_ready();
    bit ack = 1'b0;
    for (int k = 0; k < 40 && !ack; k++) begin
      bus_start();
      send_byte(AWR, ack);
      if (ack) chk(m_left == 0, "R10", "ack only after cycle end", m_left, 0);
      bus_stop();
    end
    chk(ack, "R10", "address acked once idle", int'(ack), 1);
  endtask

  initial begin
    bit ack, r;
    logic [7:0] d;
    foreach (m_mem[i]) m_mem[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    hp();

    // R11: reset state
    chk(sda_oe == 1'b0, "R11", "sda released after reset", int'(sda_oe), 0);
    chk(busy == 1'b0, "R11", "busy low after reset", int'(busy), 0);

    // R1: own address clocked in without START is ignored
    send_byte(AWR, ack);
    chk(!ack, "R1", "no ack before START", int'(ack), 0);
    bus_stop();

    // R4: foreign address is not acknowledged
    bus_start();
    send_byte(8'h8C, ack);
    chk(!ack, "R4", "foreign address nack", int'(ack), 0);
    clk_bit(1'b1, r);
    chk(r == 1'b1, "R4", "line released after mismatch", int'(r), 1);
    bus_stop();

    // R5/R6: write pointer 3, three data bytes
    bus_start();
    send_byte(AWR, ack);
    chk(ack, "R4", "own address ack", int'(ack), 1);
    send_byte(8'h03, ack);
    chk(ack, "R5", "pointer byte ack", int'(ack), 1);
    write_data(8'hA1, 3);
    write_data(8'hB2, 4);
    write_data(8'hC3, 5);
    bus_stop();
    hp();
    chk(busy == 1'b1, "R9", "busy after write STOP", int'(busy), 1);

    // R10: poll during the cycle is refused
    bus_start();
    send_byte(AWR, ack);
    chk(!ack, "R10", "address nack while busy", int'(ack), 0);
    bus_stop();
    poll_ready();

    // R7/R8: random read from 3 via repeated START
    bus_start();
    send_byte(AWR, ack);
    send_byte(8'h03, ack);
    bus_start();
    send_byte(ARD, ack);
    chk(ack, "R7", "read address ack", int'(ack), 1);
    recv_byte(1'b1, d);
    chk(d == 8'(m_mem[3]), "R7", "read byte @3", int'(d), m_mem[3]);
    recv_byte(1'b1, d);
    chk(d == 8'(m_mem[4]), "R7", "read byte @4", int'(d), m_mem[4]);
    recv_byte(1'b0, d);
    chk(d == 8'(m_mem[5]), "R11", "committed byte @5", int'(d), m_mem[5]);
    clk_bit(1'b1, r);
    chk(r == 1'b1, "R8", "released after master nack", int'(r), 1);
    bus_stop();
    hp();
    chk(busy == 1'b0, "R9", "no cycle without pending data", int'(busy), 0);
    chk(sda_oe == 1'b0, "R2", "released after STOP", int'(sda_oe), 0);

    // R6: wrap from the last entry
    bus_start();
    send_byte(AWR, ack);
    send_byte(8'(DEPTH - 1), ack);
    write_data(8'h5A, DEPTH - 1);
    write_data(8'h6B, 0);
    bus_stop();
    poll_ready();

    bus_start();
    send_byte(AWR, ack);
    send_byte(8'(DEPTH - 1), ack);
    bus_start();
    send_byte(ARD, ack);
    recv_byte(1'b1, d);
    chk(d == 8'h5A, "R6", "byte at last entry", int'(d), 8'h5A);
    recv_byte(1'b0, d);
    chk(d == 8'h6B, "R6", "byte wrapped to entry 0", int'(d), 8'h6B);
    bus_stop();

    // R7: pointer kept advancing, now at 1 (still zero from reset)
    bus_start();
    send_byte(ARD, ack);
    recv_byte(1'b0, d);
    chk(d == 8'(m_mem[1]), "R7", "read continues at pointer", int'(d), m_mem[1]);
    bus_stop();
    hp();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule